// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which oscillator drives the system clock and at what divided rate the system and I/O clock domains run. Software programs a control register with the wanted source, the two divider codes and two options. A second, read-only status register shows what the hardware has actually applied. The two sources are a 32 MHz crystal and a 16 MHz internal RC oscillator. Each oscillator is modelled as an enable output plus a stable input, and the glitch-free clock mux is modelled as a single select output.

A source change is qualified before it takes effect. The target oscillator is enabled, and its stable input must then stay high for `SETTLE_CYC` consecutive cycles. For the crystal, the amplitude-ok input must also be high when the amplitude-check option is set. Only then do the status select bit and the mux select move. Divider codes are clamped so that neither domain runs faster than the active source. The applied divider codes follow the source switch in the same cycle. When power-down is requested, an oscillator is switched off only once neither the request nor the active selection uses it.

Top module: `sysclk_switch_ctrl`

## Requirements
- R1: After reset the control register reads 0x1101 and the status register reads 0x1109 while only the RC source reports stable. This means the RC source is selected, both options are off, both divider codes are 001, `clk_sel_o` is 1 and both oscillator enables are 1.
- R2: The control register (address 0) holds the source select at bit 0 (0 = 32 MHz crystal, 1 = 16 MHz RC), the power-down option at bit 1, the amplitude-check option at bit 2, the system divider code at bits 10:8 and the I/O divider code at bits 14:12. It reads back exactly what was written in those fields, and every other bit reads 0.
- R3: Status bit 1 (switch pending) is 1 exactly while control bit 0 differs from status bit 0 (the active source).
- R4: The active source (status bit 0 and `clk_sel_o`) changes only on the edge at which the target's qualified stable signal has been high for `SETTLE_CYC` consecutive sampled edges. Any low sample restarts the count.
- R5: With the amplitude-check option set, the crystal counts as qualified only while both `xtal_stable_i` and `xtal_amp_ok_i` are high.
- R6: Divider codes 000 to 111 mean 32, 16, 8, 4, 2, 1, 0.5 and 0.25 MHz. While the RC source is active, a requested code 000 is applied as 001. While the crystal is active, every code is applied as requested.
- R7: The applied divider codes (status bits 10:8 and 14:12, also `sys_div_o` and `io_div_o`) follow a control write one cycle later when no switch is pending. They are held while a switch is pending. They are updated on the completing edge, clamped for the new source.
- R8: With power-down clear, both enables are 1. With it set, an oscillator's enable is 0 only when neither control bit 0 nor the active source selects it, so a previous source is dropped only after the switch completes.
- R9: Status bit 2 (crystal stable) and status bit 3 (RC stable) each read 1 only when that oscillator is enabled and its stable input is high.
- R10: Writes to the status address (1) change neither register nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| xtal_stable_i | input | 1 | Crystal oscillator reports settled |
| xtal_amp_ok_i | input | 1 | Crystal amplitude above threshold |
| rc_stable_i | input | 1 | RC oscillator reports settled |
| xtal_en_o | output | 1 | Crystal oscillator power enable |
| rc_en_o | output | 1 | RC oscillator power enable |
| clk_sel_o | output | 1 | Clock mux select (0 crystal, 1 RC) |
| sys_div_o | output | 3 | Applied system clock divider code |
| io_div_o | output | 3 | Applied I/O clock divider code |

## Verification
The bench builds the block with `SETTLE_CYC` = 4, `DATA_W` = 16 and amplitude checking compiled in. The short settle window lets a single dropped stable sample land in the middle of a count and be seen to restart it. It also keeps many randomised source swaps and divider writes within a short run. With amplitude checking present, a crystal that is stable but lacks amplitude can be held pending for a long stretch and then released.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
   // Divider code width is fixed by the rate encoding.
   parameter int DIV_W = 3;
   parameter int REG_MIN_W = 15;

   parameter logic SRC_XTAL = 1'b0;
   parameter logic SRC_RC   = 1'b1;

   // Control register bit positions
   parameter int C_SEL    = 0;
   parameter int C_PD     = 1;
   parameter int C_AMP    = 2;
   parameter int C_SYS_LO = 8;
   parameter int C_IO_LO  = 12;

   // Status register bit positions
   parameter int S_SEL    = 0;
   parameter int S_PEND   = 1;
   parameter int S_XSTB   = 2;
   parameter int S_RSTB   = 3;

   typedef struct packed {
      logic             sel;
      logic             pd;
      logic             amp;
      logic [DIV_W-1:0] sys_div;
      logic [DIV_W-1:0] io_div;
   } ctrl_t;
endpackage

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg
   import sysclk_pkg::*;
#(
   parameter int   DATA_W  = 16,
   parameter logic RST_SRC = SRC_RC,
   parameter int   RST_DIV = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl_q
);
   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q.sel     <= RST_SRC;
         ctrl_q.pd      <= 1'b0;
         ctrl_q.amp     <= 1'b0;
         ctrl_q.sys_div <= DIV_W'(RST_DIV);
         ctrl_q.io_div  <= DIV_W'(RST_DIV);
      end else if (we) begin
         ctrl_q.sel     <= wdata[C_SEL];
         ctrl_q.pd      <= wdata[C_PD];
         ctrl_q.amp     <= wdata[C_AMP];
         ctrl_q.sys_div <= wdata[C_SYS_LO +: DIV_W];
         ctrl_q.io_div  <= wdata[C_IO_LO +: DIV_W];
      end
   end
endmodule

// File: rtl/sysclk_settle_cnt.sv
module sysclk_settle_cnt #(
   parameter int SETTLE_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic qual,
   output logic done
);
   localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   generate
      if (SETTLE_CYC == 1) begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign done = arm & qual;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);
         logic [CNT_W-1:0] cnt_q;
         assign done = arm & qual & (cnt_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!arm || !qual || done)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sysclk_div_clamp.sv
module sysclk_div_clamp #(
   parameter int DIV_W = 3
) (
   input  logic [DIV_W-1:0] req_div,
   input  logic             rc_active,
   output logic [DIV_W-1:0] applied_div
);
   // RC tops out at half the crystal rate: the fastest code is not allowed.
   always_comb begin
      if (rc_active && (req_div == '0))
         applied_div = DIV_W'(1);
      else
         applied_div = req_div;
   end
endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
   import sysclk_pkg::*;
#(
   parameter int   DATA_W          = 16,
   parameter int   SETTLE_CYC      = 64,
   parameter bit   AMP_DET_SUPPORT = 1'b1,
   parameter logic RST_SRC         = SRC_RC,
   parameter int   RST_DIV         = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              xtal_stable_i,
   input  logic              xtal_amp_ok_i,
   input  logic              rc_stable_i,
   output logic              xtal_en_o,
   output logic              rc_en_o,
   output logic              clk_sel_o,
   output logic [DIV_W-1:0]  sys_div_o,
   output logic [DIV_W-1:0]  io_div_o
);
   localparam int N_DIV = 2;

   generate
      if (DATA_W < REG_MIN_W) begin : g_bad_width
         $error("DATA_W too narrow for register fields");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (RST_DIV < 0 || RST_DIV >= (1 << DIV_W)) begin : g_bad_div
         $error("RST_DIV out of range");
      end
      if (RST_SRC == SRC_RC && RST_DIV == 0) begin : g_bad_rst
         $error("RST_DIV 0 not allowed with RC reset source");
      end
   endgenerate

   ctrl_t ctrl_q;
   logic  stat_sel_q;
   logic  pending;
   logic  xtal_qual;
   logic  rc_qual;
   logic  tgt_qual;
   logic  done;
   logic  next_sel;
   logic  next_is_rc;
   logic [N_DIV-1:0][DIV_W-1:0] req_div;
   logic [N_DIV-1:0][DIV_W-1:0] clamp_div;
   logic [N_DIV-1:0][DIV_W-1:0] app_div_q;

   sysclk_ctrl_reg #(
      .DATA_W (DATA_W),
      .RST_SRC(RST_SRC),
      .RST_DIV(RST_DIV)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we && (reg_addr == 1'b0)),
      .wdata (reg_wdata),
      .ctrl_q(ctrl_q)
   );

   assign pending = (ctrl_q.sel != stat_sel_q);

   generate
      if (AMP_DET_SUPPORT) begin : g_amp
         assign xtal_qual = xtal_stable_i & (~ctrl_q.amp | xtal_amp_ok_i);
      end else begin : g_noamp
         logic unused_amp;
         assign unused_amp = xtal_amp_ok_i ^ ctrl_q.amp;
         assign xtal_qual  = xtal_stable_i;
      end
   endgenerate

   assign rc_qual  = rc_stable_i;
   assign tgt_qual = (ctrl_q.sel == SRC_RC) ? rc_qual : xtal_qual;

   sysclk_settle_cnt #(
      .SETTLE_CYC(SETTLE_CYC)
   ) u_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .arm  (pending),
      .qual (tgt_qual),
      .done (done)
   );

   assign next_sel   = done ? ctrl_q.sel : stat_sel_q;
   assign next_is_rc = (next_sel == SRC_RC);
   assign req_div[0] = ctrl_q.sys_div;
   assign req_div[1] = ctrl_q.io_div;

   generate
      for (genvar g = 0; g < N_DIV; g++) begin : g_clamp
         sysclk_div_clamp #(
            .DIV_W(DIV_W)
         ) u_clamp (
            .req_div    (req_div[g]),
            .rc_active  (next_is_rc),
            .applied_div(clamp_div[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_sel_q   <= RST_SRC;
         app_div_q[0] <= DIV_W'(RST_DIV);
         app_div_q[1] <= DIV_W'(RST_DIV);
      end else begin
         stat_sel_q <= next_sel;
         if (!pending || done)
            app_div_q <= clamp_div;
      end
   end

   // An oscillator stays powered while either the request or the active source uses it.
   assign xtal_en_o = ~ctrl_q.pd | (ctrl_q.sel == SRC_XTAL) | (stat_sel_q == SRC_XTAL);
   assign rc_en_o   = ~ctrl_q.pd | (ctrl_q.sel == SRC_RC)   | (stat_sel_q == SRC_RC);

   assign clk_sel_o = stat_sel_q;
   assign sys_div_o = app_div_q[0];
   assign io_div_o  = app_div_q[1];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == 1'b0) begin
         reg_rdata[C_SEL]               = ctrl_q.sel;
         reg_rdata[C_PD]                = ctrl_q.pd;
         reg_rdata[C_AMP]               = ctrl_q.amp;
         reg_rdata[C_SYS_LO +: DIV_W]   = ctrl_q.sys_div;
         reg_rdata[C_IO_LO +: DIV_W]    = ctrl_q.io_div;
      end else begin
         reg_rdata[S_SEL]               = stat_sel_q;
         reg_rdata[S_PEND]              = pending;
         reg_rdata[S_XSTB]              = xtal_stable_i & xtal_en_o;
         reg_rdata[S_RSTB]              = rc_stable_i & rc_en_o;
         reg_rdata[C_SYS_LO +: DIV_W]   = app_div_q[0];
         reg_rdata[C_IO_LO +: DIV_W]    = app_div_q[1];
      end
   end
endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk
   import sysclk_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             pend,
   input logic             qual,
   input logic             ctrl_sel,
   input logic             clk_sel_o,
   input logic             xtal_en_o,
   input logic             rc_en_o,
   input logic [DIV_W-1:0] sys_div_o,
   input logic [DIV_W-1:0] io_div_o
);
   logic armed;
   logic unused_sel;
   assign unused_sel = ctrl_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_sel_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$stable(clk_sel_o) |-> $past(pend));

   assert_sel_needs_qual_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$stable(clk_sel_o) |-> $past(qual));

   assert_xtal_drop_after_switch_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $fell(xtal_en_o) |-> (!pend && clk_sel_o == SRC_RC));

   assert_rc_drop_after_switch_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $fell(rc_en_o) |-> (!pend && clk_sel_o == SRC_XTAL));

   assert_rc_never_fastest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel_o == SRC_RC) |-> (sys_div_o != '0 && io_div_o != '0));

   assert_div_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(pend) && $stable(clk_sel_o)) |-> ($stable(sys_div_o) && $stable(io_div_o)));
endmodule

bind sysclk_switch_ctrl sysclk_switch_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pend     (pending),
   .qual     (tgt_qual),
   .ctrl_sel (ctrl_q.sel),
   .clk_sel_o(clk_sel_o),
   .xtal_en_o(xtal_en_o),
   .rc_en_o  (rc_en_o),
   .sys_div_o(sys_div_o),
   .io_div_o (io_div_o)
);

// File: tb/sysclk_switch_ctrl_tb.sv
`timescale 1ns/1ps
module sysclk_switch_ctrl_tb;
   localparam int DATA_W = 16;
   localparam int SETTLE = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic              reg_addr = 1'b0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              xtal_stable_i = 1'b0;
   logic              xtal_amp_ok_i = 1'b0;
   logic              rc_stable_i = 1'b1;
   logic              xtal_en_o, rc_en_o, clk_sel_o;
   logic [2:0]        sys_div_o, io_div_o;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   sysclk_switch_ctrl #(
      .DATA_W(DATA_W), .SETTLE_CYC(SETTLE), .AMP_DET_SUPPORT(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .xtal_stable_i(xtal_stable_i), .xtal_amp_ok_i(xtal_amp_ok_i),
      .rc_stable_i(rc_stable_i), .xtal_en_o(xtal_en_o), .rc_en_o(rc_en_o),
      .clk_sel_o(clk_sel_o), .sys_div_o(sys_div_o), .io_div_o(io_div_o)
   );

   function automatic logic [2:0] clamp(input logic [2:0] code, input logic rc);
      return (rc && code == 3'd0) ? 3'd1 : code;
   endfunction

   function automatic logic [15:0] ctrl_word(input logic sel, input logic pd, input logic amp,
                                             input logic [2:0] sd, input logic [2:0] id);
      return {1'b0, id, 1'b0, sd, 5'd0, amp, pd, sel};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic addr, input logic [15:0] data);
      reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = 1'b0;
   endtask

   task automatic rd(input logic addr, output logic [15:0] data);
      reg_addr = addr;
      #0.5;
      data = reg_rdata;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      logic cur_sel;
      void'($urandom(32'd1234));
      #10;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(1'b0, d); check("R1 ctrl reset", d, 16'h1101);
      rd(1'b1, d); check("R1 status reset", d, 16'h1109);
      check("R1 clk_sel", clk_sel_o, 1);
      check("R1 enables", {xtal_en_o, rc_en_o}, 2'b11);

      // R6/R7: RC active, code 000 clamps, applied one cycle later
      wr(1'b0, ctrl_word(1'b1, 1'b0, 1'b0, 3'd0, 3'd3));
      check("R7 not yet applied", {sys_div_o, io_div_o}, {3'd1, 3'd1});
      @(posedge clk); @(negedge clk);
      check("R6 rc clamp sys", sys_div_o, 3'd1);
      check("R7 io applied", io_div_o, 3'd3);

      // R2 readback masking, R8 power-down, R9 stable gating
      xtal_stable_i = 1'b1;
      wr(1'b0, 16'hFFFF);
      rd(1'b0, d); check("R2 readback mask", d, 16'h7707);
      check("R8 xtal powered down", xtal_en_o, 0);
      check("R8 rc kept", rc_en_o, 1);
      rd(1'b1, d); check("R9 xtal stable masked", d[2], 0);

      // R10 status writes ignored
      wr(1'b1, 16'h0000);
      rd(1'b0, d); check("R10 ctrl unchanged", d, 16'h7707);
      rd(1'b1, d); check("R10 status unchanged", d, 16'h7709);
      check("R10 clk_sel unchanged", clk_sel_o, 1);

      // R5 amplitude gating, R8 ordering, R3 pending
      wr(1'b0, ctrl_word(1'b0, 1'b1, 1'b1, 3'd0, 3'd2));
      rd(1'b1, d); check("R3 pending set", d[1], 1);
      check("R9 xtal stable visible", d[2], 1);
      check("R8 target enabled", {xtal_en_o, rc_en_o}, 2'b11);
      repeat (10) @(posedge clk);
      @(negedge clk);
      check("R5 held without amplitude", clk_sel_o, 1);
      check("R7 divs held while pending", {sys_div_o, io_div_o}, {3'd7, 3'd7});
      xtal_amp_ok_i = 1'b1;
      repeat (SETTLE - 1) @(posedge clk);
      @(negedge clk);
      rd(1'b1, d); check("R4 still pending before window", d[1:0], 2'b11);
      @(posedge clk); @(negedge clk);
      check("R4 switched to crystal", clk_sel_o, 0);
      check("R6 crystal no clamp", {sys_div_o, io_div_o}, {3'd0, 3'd2});
      check("R8 old source dropped after", rc_en_o, 0);
      rd(1'b1, d); check("R3 pending cleared", d[1], 0);

      // R4 restart on a dropped stable sample
      wr(1'b0, ctrl_word(1'b1, 1'b0, 1'b0, 3'd0, 3'd0));
      repeat (2) @(posedge clk);
      @(negedge clk); rc_stable_i = 1'b0;
      @(posedge clk);
      @(negedge clk); rc_stable_i = 1'b1;
      repeat (SETTLE - 1) @(posedge clk);
      @(negedge clk);
      check("R4 count restarted", clk_sel_o, 0);
      @(posedge clk); @(negedge clk);
      check("R4 switched to rc", clk_sel_o, 1);
      check("R6 clamp at switch", {sys_div_o, io_div_o}, {3'd1, 3'd1});

      // Random source swaps and divider writes
      xtal_stable_i = 1'b1; xtal_amp_ok_i = 1'b1; rc_stable_i = 1'b1;
      cur_sel = 1'b1;
      for (int i = 0; i < 40; i++) begin
         logic s, p, a;
         logic [2:0] sd, id;
         s = 1'($urandom); p = 1'($urandom); a = 1'($urandom);
         sd = 3'($urandom); id = 3'($urandom);
         wr(1'b0, ctrl_word(s, p, a, sd, id));
         if (s != cur_sel) repeat (SETTLE - 1) @(posedge clk);
         @(posedge clk); @(negedge clk);
         cur_sel = s;
         check("R4 random select", clk_sel_o, s);
         check("R6 random sys", sys_div_o, clamp(sd, s));
         check("R7 random io", io_div_o, clamp(id, s));
         check("R8 random enables", {xtal_en_o, rc_en_o}, {(!p || !s), (!p || s)});
         rd(1'b1, d); check("R3 random pending", d[1], 0);
      end

      finish_run();
   end
endmodule